// File: doc/BRIEF.md
# Chained Converter Result Serializer

This block is the serial read-out port of a 14-bit converter. It has a conversion timer, a holding register for the last result, and a shift path that puts the result onto a serial data line. The line is paced by a host clock (SCLK) and framed by an active-low select. The converter core is outside the block. The block tells the core which input channel to use. At the end of the conversion window it captures the core's parallel word, and it tags the result with that channel. A single-cycle active-low end-of-conversion flag marks each update of the result register.

The port works in one of two ways, set by `cfg_chain`:

- **Standalone.** A read command is shifted in on the first four SCLKs of a frame. The result leaves MSB first on the same edges. When `cfg_tag` is set, the channel tag and then zeros follow the data.
- **Chained.** Several devices share SCLK and the frame select. Each device's output feeds the next device's serial input. In one long frame the last device sends its own fixed-length slot first, and after that it passes on what the upstream devices sent. A device that was not told to convert sends its older result again.

The serial stream has no back-pressure of its own. The host decides the pace by how fast it toggles SCLK, and decides the length by how long it holds the frame. SCLK, frame select and serial input are resynchronised to the block clock. The block clock also serves as the conversion clock, and it must run at least eight times faster than SCLK.

Top module: `crs_chain_readout`

## Requirements
- R1: After reset, `sdo` is 0, `eoc_n` is 1 and `chan_sel` is 0 (with `cfg_auto` = 0 and `chan_manual` = 0).
- R2: A `conv_start` accepted at clock edge E0 gives exactly one low cycle of `eoc_n`, right after edge E0+18, when no frame is active. This is also when the result register takes the core word that was present at edge E0+17.
- R3: `conv_start` is ignored while a conversion is running. It is also ignored until three clocks of sampling time have passed after the capture edge. A start held during the `eoc_n` low cycle has no effect.
- R4: A conversion that ends while the frame is active does not update the result register and does not pulse `eoc_n` until the frame ends. That frame still carries the older result.
- R5: Standalone, tag off. The frame sends the 14 result bits MSB first, beginning when the frame opens, with one new bit after each falling SCLK edge. Every bit after the 14th is 0.
- R6: Standalone, tag on. Bit 14 (counting from 0) is the channel tag, and every later bit is 0.
- R7: Standalone. The first four SDI bits are taken MSB first on rising SCLK edges. If they differ from the read code 1101b, `sdo` stays 0 from bit 4 until the frame ends.
- R8: Chained, tag off. Each slot is 16 bits: 14 data bits, then two zeros. After its own slot, the device outputs the SDI bits it took, 16 bits later.
- R9: Chained, tag on. Each slot is 24 bits: 14 data bits, two zeros, the tag, then seven zeros. SDI comes back out 24 bits later.
- R10: A chained device that was not started sends the result it held from its last conversion.
- R11: With `cfg_auto` = 0, `chan_sel` follows `chan_manual`. With `cfg_auto` = 1, `chan_sel` toggles after each conversion capture and holds still otherwise. The tag of a result is the `chan_sel` value at the moment the start was accepted. The auto setting leaves the frame layout unchanged.
- R12: While the frame select is high, `sdo` is 0. The first four SDI bits of a chained frame are forwarded as data and are not decoded as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Request to begin a conversion (synchronous, level) |
| core_data | input | 14 | Parallel result word from the converter core |
| chan_manual | input | 1 | Channel choice used when auto select is off |
| chan_sel | output | 1 | Channel the core should sample |
| cfg_chain | input | 1 | 1 = chained slot format, 0 = standalone |
| cfg_tag | input | 1 | 1 = append the channel tag |
| cfg_auto | input | 1 | 1 = channel toggles after each conversion |
| sclk | input | 1 | Serial clock from the host |
| frame_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial input: command or upstream data |
| sdo | output | 1 | Serial output |
| eoc_n | output | 1 | Active-low one-cycle result-update flag |

## Verification
After a start is accepted at a clock edge, `eoc_n` falls 18 edges later. The bench counts edges from the start edge and samples `eoc_n` on the falling clock edge between two edges. A serial bit is guaranteed within four block clocks after the SCLK edge that moved it. The bench holds each SCLK phase for eight block clocks and takes every bit just before the next rising SCLK edge. When the frame select is raised, a deferred update shows up within a few clocks. The bench therefore takes an `eoc_n` count just before releasing the frame and compares it with a second count taken well after release.

// File: rtl/crs_pkg.sv
package crs_pkg;
  localparam int CMD_W = 4;
  localparam logic [CMD_W-1:0] CMD_READ = 4'b1101;

  typedef enum logic {TMR_SAMPLE, TMR_CONVERT} tmr_state_t;

  typedef struct packed {
    logic chain;
    logic tag;
  } frame_mode_t;
endpackage

// File: rtl/crs_conv_timer.sv
module crs_conv_timer #(
  parameter int CONV_CLKS  = 18,
  parameter int SAMPLE_MIN = 3,
  localparam int CW = $clog2(CONV_CLKS + 1),
  localparam int SW = $clog2(SAMPLE_MIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          accept,
  output logic          cap,
  output logic          busy,
  output logic [CW-1:0] elapsed
);
  import crs_pkg::*;

  tmr_state_t    st;
  logic [CW-1:0] cnt;
  logic [SW-1:0] scnt;

  assign busy    = (st == TMR_CONVERT);
  assign accept  = (st == TMR_SAMPLE) && start && (scnt == SW'(SAMPLE_MIN));
  assign cap     = busy && (cnt == CW'(CONV_CLKS - 1));
  assign elapsed = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= TMR_SAMPLE;
      cnt  <= '0;
      scnt <= SW'(SAMPLE_MIN);
    end else begin
      if (accept) begin
        st  <= TMR_CONVERT;
        cnt <= CW'(1);
      end else if (cap) begin
        st   <= TMR_SAMPLE;
        cnt  <= '0;
        scnt <= '0;
      end else if (busy) begin
        cnt <= cnt + CW'(1);
      end
      if (!busy && scnt != SW'(SAMPLE_MIN))
        scnt <= scnt + SW'(1);
    end
  end
endmodule

// File: rtl/crs_result_hold.sv
module crs_result_hold #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              cap,
  input  logic [DATA_W-1:0] core_data,
  input  logic              cfg_auto,
  input  logic              chan_manual,
  input  logic              frame_act,
  output logic              chan_sel,
  output logic [DATA_W-1:0] res_data,
  output logic              res_tag,
  output logic              eoc_n
);
  logic              auto_ch;
  logic              chan_conv;
  logic [DATA_W-1:0] pend_data;
  logic              pend_tag;
  logic              pend_v;

  assign chan_sel = cfg_auto ? auto_ch : chan_manual;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_ch   <= 1'b0;
      chan_conv <= 1'b0;
      pend_data <= '0;
      pend_tag  <= 1'b0;
      pend_v    <= 1'b0;
      res_data  <= '0;
      res_tag   <= 1'b0;
      eoc_n     <= 1'b1;
    end else begin
      if (accept) chan_conv <= chan_sel;
      if (pend_v && !frame_act) begin
        res_data <= pend_data;
        res_tag  <= pend_tag;
        pend_v   <= 1'b0;
        eoc_n    <= 1'b0;
      end else begin
        eoc_n <= 1'b1;
      end
      if (cap) begin
        pend_data <= core_data;
        pend_tag  <= chan_conv;
        pend_v    <= 1'b1;
        if (cfg_auto) auto_ch <= ~auto_ch;
      end
    end
  end
endmodule

// File: rtl/crs_serial_port.sv
module crs_serial_port #(
  parameter int DATA_W   = 14,
  parameter int SLOT_PAD = 2,
  parameter int TAG_BYTE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_act,
  input  logic              rise,
  input  logic              fall,
  input  logic              sdi,
  input  logic              cfg_chain,
  input  logic              cfg_tag,
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_tag,
  output logic              sdo
);
  import crs_pkg::*;

  localparam int SR_W       = DATA_W + SLOT_PAD + TAG_BYTE;
  localparam int INS_SHORT  = TAG_BYTE;
  localparam int SOLO_TAG   = SR_W - DATA_W - 1;
  localparam int CHAIN_TAG  = TAG_BYTE - 1;
  localparam int CNT_W      = $clog2(CMD_W + 1);

  logic [SR_W-1:0]    sr, load_w, shf_w;
  logic [CMD_W-2:0]   cmd;
  logic [CMD_W-1:0]   cmd_nxt;
  logic [CNT_W-1:0]   cnt;
  logic               frame_q, abort, sdi_q;
  logic               start;
  frame_mode_t        mode;

  assign start   = frame_act && !frame_q;
  assign cmd_nxt = {cmd, sdi};

  always_comb begin
    load_w = '0;
    load_w[SR_W-1 -: DATA_W] = res_data;
    if (cfg_tag) begin
      if (cfg_chain) load_w[CHAIN_TAG] = res_tag;
      else           load_w[SOLO_TAG]  = res_tag;
    end
  end

  always_comb begin
    shf_w = {sr[SR_W-2:0], 1'b0};
    if (mode.chain) begin
      if (mode.tag) shf_w[0]         = sdi_q;
      else          shf_w[INS_SHORT] = sdi_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      cmd     <= '0;
      cnt     <= '0;
      frame_q <= 1'b0;
      abort   <= 1'b0;
      sdi_q   <= 1'b0;
      mode    <= '0;
      sdo     <= 1'b0;
    end else begin
      frame_q <= frame_act;
      sdo     <= frame_act && !start && !abort && sr[SR_W-1];
      if (!frame_act) begin
        cnt   <= '0;
        abort <= 1'b0;
      end else if (start) begin
        sr         <= load_w;
        mode.chain <= cfg_chain;
        mode.tag   <= cfg_tag;
        cnt        <= '0;
        cmd        <= '0;
        abort      <= 1'b0;
      end else begin
        if (rise) begin
          sdi_q <= sdi;
          if (cnt < CNT_W'(CMD_W)) begin
            cmd <= cmd_nxt[CMD_W-2:0];
            cnt <= cnt + CNT_W'(1);
            if (cnt == CNT_W'(CMD_W - 1) && !mode.chain && cmd_nxt != CMD_READ)
              abort <= 1'b1;
          end
        end
        if (fall) sr <= shf_w;
      end
    end
  end
endmodule

// File: rtl/crs_chain_readout.sv
module crs_chain_readout #(
  parameter int DATA_W      = 14,
  parameter int CONV_CLKS   = 18,
  parameter int SAMPLE_MIN  = 3,
  parameter int SYNC_STAGES = 2,
  parameter int SLOT_PAD    = 2,
  parameter int TAG_BYTE    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_start,
  input  logic [DATA_W-1:0] core_data,
  input  logic              chan_manual,
  output logic              chan_sel,
  input  logic              cfg_chain,
  input  logic              cfg_tag,
  input  logic              cfg_auto,
  input  logic              sclk,
  input  logic              frame_n,
  input  logic              sdi,
  output logic              sdo,
  output logic              eoc_n
);
  localparam int TMR_CW = $clog2(CONV_CLKS + 1);
  localparam int LAST   = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclk_s, frame_s, sdi_s;
  logic                   sclk_q;
  logic                   frame_act, rise, fall;
  logic                   tmr_accept, tmr_cap, tmr_busy;
  logic [TMR_CW-1:0]      tmr_cnt;
  logic [DATA_W-1:0]      res_data;
  logic                   res_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s  <= '0;
      frame_s <= '1;
      sdi_s   <= '0;
      sclk_q  <= 1'b0;
    end else begin
      sclk_s[0]  <= sclk;
      frame_s[0] <= frame_n;
      sdi_s[0]   <= sdi;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        sclk_s[i]  <= sclk_s[i-1];
        frame_s[i] <= frame_s[i-1];
        sdi_s[i]   <= sdi_s[i-1];
      end
      sclk_q <= sclk_s[LAST];
    end
  end

  assign frame_act = !frame_s[LAST];
  assign rise      = sclk_s[LAST] && !sclk_q;
  assign fall      = !sclk_s[LAST] && sclk_q;

  crs_conv_timer #(
    .CONV_CLKS(CONV_CLKS), .SAMPLE_MIN(SAMPLE_MIN)
  ) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(conv_start), .accept(tmr_accept),
    .cap(tmr_cap), .busy(tmr_busy), .elapsed(tmr_cnt)
  );

  crs_result_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .accept(tmr_accept), .cap(tmr_cap),
    .core_data(core_data), .cfg_auto(cfg_auto), .chan_manual(chan_manual),
    .frame_act(frame_act), .chan_sel(chan_sel), .res_data(res_data),
    .res_tag(res_tag), .eoc_n(eoc_n)
  );

  crs_serial_port #(
    .DATA_W(DATA_W), .SLOT_PAD(SLOT_PAD), .TAG_BYTE(TAG_BYTE)
  ) u_port (
    .clk(clk), .rst_n(rst_n), .frame_act(frame_act), .rise(rise), .fall(fall),
    .sdi(sdi_s[LAST]), .cfg_chain(cfg_chain), .cfg_tag(cfg_tag),
    .res_data(res_data), .res_tag(res_tag), .sdo(sdo)
  );
endmodule

// File: rtl/crs_chain_readout_chk.sv
module crs_chain_readout_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sdo,
  input logic             eoc_n,
  input logic             frame_act,
  input logic             tmr_busy,
  input logic             tmr_cap,
  input logic [CNT_W-1:0] tmr_cnt,
  input logic             cfg_auto,
  input logic             chan_sel
);
  p_sdo_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_act |=> !sdo)
    else $error("sdo high outside a frame");

  p_eoc_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc_n |=> eoc_n)
    else $error("eoc_n low longer than one cycle");

  p_no_update_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_act |=> eoc_n)
    else $error("result updated during a frame");

  p_busy_counts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_busy && !tmr_cap |=> tmr_busy && (tmr_cnt == $past(tmr_cnt) + CNT_W'(1)))
    else $error("conversion window disturbed");

  p_chan_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_auto && $past(cfg_auto) && !$past(tmr_cap) |-> $stable(chan_sel))
    else $error("auto channel moved without a capture");
endmodule

bind crs_chain_readout crs_chain_readout_chk #(.CNT_W(TMR_CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sdo(sdo), .eoc_n(eoc_n), .frame_act(frame_act),
  .tmr_busy(tmr_busy), .tmr_cap(tmr_cap), .tmr_cnt(tmr_cnt),
  .cfg_auto(cfg_auto), .chan_sel(chan_sel)
);

// File: tb/crs_chain_readout_test.sv
module crs_chain_readout_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int MAXB = 72;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st1 = 0, st2 = 0, st3 = 0;
  logic [13:0] d1 = 0, d2 = 0, d3 = 0;
  logic chan_manual = 0, cfg_chain = 0, cfg_tag = 0, cfg_auto = 0;
  logic sclk = 0, frame_n = 1, sdi = 0;
  logic sdo1, sdo2, sdo3, eoc1, eoc2, eoc3, cs1, cs2, cs3;

  int tests = 0, fails = 0, eoc_cnt = 0, eoc_snap = 0;
  logic cap [0:MAXB-1];
  logic [13:0] rd [0:2];
  logic rt [0:2];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crs_chain_readout uut (.clk(clk), .rst_n(rst_n), .conv_start(st1), .core_data(d1),
    .chan_manual(chan_manual), .chan_sel(cs1), .cfg_chain(cfg_chain), .cfg_tag(cfg_tag),
    .cfg_auto(cfg_auto), .sclk(sclk), .frame_n(frame_n), .sdi(sdi), .sdo(sdo1), .eoc_n(eoc1));
  crs_chain_readout uut_b (.clk(clk), .rst_n(rst_n), .conv_start(st2), .core_data(d2),
    .chan_manual(chan_manual), .chan_sel(cs2), .cfg_chain(cfg_chain), .cfg_tag(cfg_tag),
    .cfg_auto(cfg_auto), .sclk(sclk), .frame_n(frame_n), .sdi(sdo1), .sdo(sdo2), .eoc_n(eoc2));
  crs_chain_readout uut_c (.clk(clk), .rst_n(rst_n), .conv_start(st3), .core_data(d3),
    .chan_manual(chan_manual), .chan_sel(cs3), .cfg_chain(cfg_chain), .cfg_tag(cfg_tag),
    .cfg_auto(cfg_auto), .sclk(sclk), .frame_n(frame_n), .sdi(sdo2), .sdo(sdo3), .eoc_n(eoc3));

  always @(negedge clk) if (rst_n && !eoc1) eoc_cnt++;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input int nbits, input logic [3:0] cmd, input bit tail);
    @(negedge clk) frame_n = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 4) ? cmd[3-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      cap[i] = tail ? sdo3 : sdo1;
      sclk = 1;
      repeat (HALF) @(negedge clk);
      sclk = 0;
    end
    repeat (HALF) @(negedge clk);
    eoc_snap = eoc_cnt;
    frame_n = 1;
    repeat (4*HALF) @(negedge clk);
  endtask

  // left-aligned 24-bit image of one device's bits
  function automatic logic [23:0] image(input logic [13:0] d, input logic t,
                                        input bit chain, input bit tg);
    logic [23:0] w;
    w = {d, 10'b0};
    if (tg) begin
      if (chain) w[7] = t;
      else       w[9] = t;
    end
    return w;
  endfunction

  task automatic cmp_solo(input int nbits, input logic [13:0] d, input logic t,
                          input bit tg, input bit abort, input string req);
    int bad; logic a; logic e; logic [23:0] w;
    bad = -1; a = 0; e = 0;
    w = image(d, t, 1'b0, tg);
    for (int i = 0; i < nbits; i++) begin
      logic x;
      x = (abort && i >= 4) ? 1'b0 : ((i < 24) ? w[23-i] : 1'b0);
      if (bad < 0 && cap[i] !== x) begin bad = i; a = cap[i]; e = x; end
    end
    chk(bad < 0, req, longint'(a), longint'(e));
    if (bad >= 0) $display("  first mismatch at bit %0d", bad);
  endtask

  task automatic cmp_chain(input bit tg, input string req);
    int slot, bad; logic a, e; logic [23:0] w;
    slot = tg ? 24 : 16;
    bad = -1; a = 0; e = 0;
    for (int i = 0; i < 3*slot; i++) begin
      int dev;
      dev = 2 - (i / slot);
      w = image(rd[dev], rt[dev], 1'b1, tg);
      if (bad < 0 && cap[i] !== w[23 - (i % slot)]) begin
        bad = i; a = cap[i]; e = w[23 - (i % slot)];
      end
    end
    chk(bad < 0, req, longint'(a), longint'(e));
    if (bad >= 0) $display("  first mismatch at bit %0d", bad);
  endtask

  task automatic convert(input bit g1, input bit g2, input bit g3);
    logic c1, c2, c3;
    @(negedge clk);
    c1 = cs1; c2 = cs2; c3 = cs3;
    st1 = g1; st2 = g2; st3 = g3;
    @(negedge clk) begin st1 = 0; st2 = 0; st3 = 0; end
    repeat (30) @(negedge clk);
    if (g1) begin rd[0] = d1; rt[0] = c1; end
    if (g2) begin rd[1] = d2; rt[1] = c2; end
    if (g3) begin rd[2] = d3; rt[2] = c3; end
  endtask

  task automatic measure(input bit extra, output int k);
    logic c;
    @(negedge clk) begin c = cs1; st1 = 1; end
    @(posedge clk);
    @(negedge clk) st1 = 0;
    k = 0;
    while (k < 60) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (extra && k == 5) st1 = 1;
      if (extra && k == 6) st1 = 0;
      if (!eoc1) break;
    end
    rd[0] = d1; rt[0] = c;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int k, e0;
    logic [13:0] vals [0:3];
    vals[0] = 14'h3FFF; vals[1] = 14'h2AAA; vals[2] = 14'h1555; vals[3] = 14'h2001;
    for (int i = 0; i < 3; i++) begin rd[i] = 0; rt[i] = 0; end

    repeat (4) @(negedge clk);
    chk(sdo1 == 0, "R1 sdo at reset", sdo1, 0);
    chk(eoc1 == 1, "R1 eoc_n at reset", eoc1, 1);
    chk(cs1 == 0, "R1 chan_sel at reset", cs1, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R2 / R3 timing
    d1 = 14'h1234;
    e0 = eoc_cnt;
    measure(1'b0, k);
    chk(k == 18, "R2 eoc_n latency", k, 18);
    st1 = 1;                       // presented during the eoc_n low cycle
    @(negedge clk) st1 = 0;
    repeat (40) @(negedge clk);
    chk(eoc_cnt == e0 + 1, "R3 start in eoc cycle ignored", eoc_cnt - e0, 1);
    e0 = eoc_cnt;
    measure(1'b1, k);
    chk(k == 18, "R3 start during conversion ignored", k, 18);
    repeat (40) @(negedge clk);
    chk(eoc_cnt == e0 + 1, "R3 single update", eoc_cnt - e0, 1);

    // standalone sweep: R5 R6 R11
    cfg_chain = 0;
    for (int au = 0; au < 2; au++) begin
      for (int tg = 0; tg < 2; tg++) begin
        for (int v = 0; v < 4; v++) begin
          logic pre;
          cfg_auto = au[0]; cfg_tag = tg[0]; chan_manual = v[0];
          d1 = vals[v];
          repeat (2) @(negedge clk);
          pre = cs1;
          convert(1, 0, 0);
          if (au == 1) chk(cs1 == ~pre, "R11 auto toggle", cs1, ~pre);
          else         chk(cs1 == chan_manual, "R11 manual channel", cs1, chan_manual);
          run_frame(20, 4'b1101, 1'b0);
          cmp_solo(20, rd[0], rt[0], tg[0], 1'b0, tg ? "R6 tagged standalone frame" : "R5 plain standalone frame");
        end
      end
    end
    cfg_auto = 0;

    // R7 wrong command
    cfg_tag = 1; chan_manual = 1; d1 = 14'h3FFF;
    convert(1, 0, 0);
    run_frame(20, 4'b1011, 1'b0);
    cmp_solo(20, rd[0], rt[0], 1'b1, 1'b1, "R7 wrong command silences sdo");
    run_frame(20, 4'b1101, 1'b0);
    cmp_solo(20, rd[0], rt[0], 1'b1, 1'b0, "R7 read command frame");
    chk(sdo1 == 0, "R12 sdo idle after frame", sdo1, 0);

    // R4 deferred update
    cfg_tag = 0; d1 = 14'h0F0F;
    e0 = eoc_cnt;
    @(negedge clk) st1 = 1;
    @(negedge clk) st1 = 0;
    run_frame(20, 4'b1101, 1'b0);
    chk(eoc_snap == e0, "R4 no update inside frame", eoc_snap - e0, 0);
    cmp_solo(20, rd[0], rt[0], 1'b0, 1'b0, "R4 frame carries old result");
    chk(eoc_cnt == e0 + 1, "R4 update after frame", eoc_cnt - e0, 1);
    rd[0] = 14'h0F0F; rt[0] = chan_manual;
    run_frame(20, 4'b1101, 1'b0);
    cmp_solo(20, rd[0], rt[0], 1'b0, 1'b0, "R4 next frame carries new result");

    // chain: R8 R9 R10 R12
    cfg_chain = 1;
    for (int tg = 0; tg < 2; tg++) begin
      cfg_tag = tg[0]; chan_manual = tg[0];
      d1 = 14'h2C01 ^ 14'(tg); d2 = 14'h1B72; d3 = 14'h3E5A;
      convert(1, 1, 1);
      run_frame(tg ? 72 : 48, 4'b1101, 1'b1);
      cmp_chain(tg[0], tg ? "R9 chained tagged stream" : "R8 chained plain stream");
      chan_manual = ~tg[0];
      d1 = 14'h0333; d2 = 14'h3FFF; d3 = 14'h2468;
      convert(1, 0, 1);
      run_frame(tg ? 72 : 48, 4'b0000, 1'b1);
      cmp_chain(tg[0], "R10 unstarted device resends old result, R12 no command decode");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule